// File: doc/BRIEF.md
# Registered Bus Exchanger

This block links a single 12-bit A side with two 12-bit B lanes (lane 1 and lane 2) through clocked storage only. Going from A toward B, each lane owns a register with its own active-low load enable, so a host can drop one A word into lane 1 on one clock and a second A word into lane 2 on the next, then present both lanes together as a 24-bit word. Going from B toward A, one shared return register captures either lane and drives the A side.

The lane select and the three active-low output enables are themselves captured on the rising clock edge, so every change of direction, selection or drive is synchronous and takes effect one edge after it is sampled. Each bidirectional pin group is modelled as an input bus, an output bus and an active-high drive flag, so the surrounding pad logic decides when the output actually reaches the wire.

Top module: `bus_exchanger`

## Requirements
- R1: While rst_ni is low, all data registers read zero, all three drive flags are 0, and the registered select points at lane 1.
- R2: On a rising edge with ld1_ni low, b1_o takes the value of a_i; with ld1_ni high, b1_o keeps its value.
- R3: On a rising edge with ld2_ni low, b2_o takes the value of a_i; with ld2_ni high, b2_o keeps its value.
- R4: When ld1_ni and ld2_ni are both low on the same edge, both lanes load the identical A word.
- R5: Loading word W1 with only ld1_ni low and, on the following edge, word W2 with only ld2_ni low yields {b2_o, b1_o} equal to {W2, W1} as one 24-bit word.
- R6: On each rising edge the return register loads b1_i if the registered select is 1 and b2_i if it is 0; a_o shows the return register.
- R7: a_o and both lane outputs change only at a rising clock edge; changes on a_i, b1_i or b2_i between edges leave them unchanged.
- R8: sel_i is sampled into the select register on an edge and steers the return capture on the following edge, so a new select value affects a_o two edges after it is first sampled.
- R9: Each drive flag (a_drv_o, b1_drv_o, b2_drv_o) equals the inverse of its active-low enable input (oe_a_ni, oe_b1_ni, oe_b2_ni) as sampled at the most recent edge; a change between edges has no effect until the next edge.
- R10: The three enables are independent: each flag follows only its own enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 12 | Data arriving on the A side |
| a_o | output | 12 | Return register contents for the A side |
| a_drv_o | output | 1 | A side drive flag, 1 = drive |
| ld1_ni | input | 1 | Active-low load enable of lane 1 register |
| ld2_ni | input | 1 | Active-low load enable of lane 2 register |
| b1_i | input | 12 | Data arriving on lane 1 |
| b2_i | input | 12 | Data arriving on lane 2 |
| b1_o | output | 12 | Lane 1 register contents |
| b2_o | output | 12 | Lane 2 register contents |
| b1_drv_o | output | 1 | Lane 1 drive flag, 1 = drive |
| b2_drv_o | output | 1 | Lane 2 drive flag, 1 = drive |
| sel_i | input | 1 | Return select, 1 = lane 1, 0 = lane 2 |
| oe_a_ni | input | 1 | Active-low output enable for the A side |
| oe_b1_ni | input | 1 | Active-low output enable for lane 1 |
| oe_b2_ni | input | 1 | Active-low output enable for lane 2 |

## Verification
The assertions check on every cycle that each lane either loads the previous A word or holds, that a_o matches the lane chosen by the select sampled two edges earlier, and that each drive flag mirrors its own enable from the previous edge. Only the bench scenarios can show the 24-bit packing of two consecutive words, that mid-cycle input changes leave all outputs untouched until the next edge, and the reset values including the lane 1 default of the select.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef struct packed {
    logic sel;
    logic drv_a;
    logic drv_b1;
    logic drv_b2;
  } bx_ctrl_t;

  localparam bx_ctrl_t BX_CTRL_RST = '{sel: 1'b1, drv_a: 1'b0, drv_b1: 1'b0, drv_b2: 1'b0};
endpackage

// File: rtl/bx_lane_reg.sv
module bx_lane_reg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (!ld_ni) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bx_ctrl_reg.sv
module bx_ctrl_reg
  import bx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  logic     oe_a_ni,
  input  logic     oe_b1_ni,
  input  logic     oe_b2_ni,
  output bx_ctrl_t ctrl_o
);
  bx_ctrl_t ctrl_d, ctrl_q;

  always_comb begin
    ctrl_d.sel    = sel_i;
    ctrl_d.drv_a  = ~oe_a_ni;
    ctrl_d.drv_b1 = ~oe_b1_ni;
    ctrl_d.drv_b2 = ~oe_b2_ni;
  end

  // outputs stay undriven until the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= BX_CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bx_return_reg.sv
module bx_return_reg #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sel_q_i,
  input  logic [LANES-1:0][DATA_W-1:0] lane_i,
  output logic [DATA_W-1:0]            q_o
);
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] q_q;

  // select 1 picks lane index 0, select 0 picks lane index 1
  assign pick = sel_q_i ? lane_i[0] : lane_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= pick;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_drv_o,
  input  logic              ld1_ni,
  input  logic              ld2_ni,
  input  logic [DATA_W-1:0] b1_i,
  input  logic [DATA_W-1:0] b2_i,
  output logic [DATA_W-1:0] b1_o,
  output logic [DATA_W-1:0] b2_o,
  output logic              b1_drv_o,
  output logic              b2_drv_o,
  input  logic              sel_i,
  input  logic              oe_a_ni,
  input  logic              oe_b1_ni,
  input  logic              oe_b2_ni
);
  localparam int unsigned LANES = 2;

  bx_ctrl_t                    ctrl;
  logic [LANES-1:0]            lane_ld_n;
  logic [LANES-1:0][DATA_W-1:0] lane_q;
  logic [LANES-1:0][DATA_W-1:0] lane_in;

  assign lane_ld_n = {ld2_ni, ld1_ni};
  assign lane_in   = {b2_i, b1_i};

  bx_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .oe_a_ni  (oe_a_ni),
    .oe_b1_ni (oe_b1_ni),
    .oe_b2_ni (oe_b2_ni),
    .ctrl_o   (ctrl)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bx_lane_reg #(.DATA_W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_ni  (lane_ld_n[g]),
      .d_i    (a_i),
      .q_o    (lane_q[g])
    );
  end

  bx_return_reg #(.DATA_W(DATA_W), .LANES(LANES)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_q_i (ctrl.sel),
    .lane_i  (lane_in),
    .q_o     (a_o)
  );

  assign b1_o     = lane_q[0];
  assign b2_o     = lane_q[1];
  assign a_drv_o  = ctrl.drv_a;
  assign b1_drv_o = ctrl.drv_b1;
  assign b2_drv_o = ctrl.drv_b2;
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] a_o,
  input logic              a_drv_o,
  input logic              ld1_ni,
  input logic              ld2_ni,
  input logic [DATA_W-1:0] b1_i,
  input logic [DATA_W-1:0] b2_i,
  input logic [DATA_W-1:0] b1_o,
  input logic [DATA_W-1:0] b2_o,
  input logic              b1_drv_o,
  input logic              b2_drv_o,
  input logic              sel_i,
  input logic              oe_a_ni,
  input logic              oe_b1_ni,
  input logic              oe_b2_ni
);
  logic past_ok, past_ok2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok  <= 1'b0;
      past_ok2 <= 1'b0;
    end else begin
      past_ok  <= 1'b1;
      past_ok2 <= past_ok;
    end
  end

  assert_lane1_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ld1_ni) |-> b1_o == $past(a_i));
  assert_lane1_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ld1_ni) |-> $stable(b1_o));
  assert_lane2_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ld2_ni) |-> b2_o == $past(a_i));
  assert_lane2_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ld2_ni) |-> $stable(b2_o));
  assert_both_same_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ld1_ni) && !$past(ld2_ni) |-> b1_o == b2_o);
  // R6 and R8: select sampled two edges back steers the capture one edge back
  assert_return_pick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok2 |-> a_o == ($past(sel_i, 2) ? $past(b1_i) : $past(b2_i)));
  assert_drv_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> a_drv_o == !$past(oe_a_ni));
  assert_drv_b1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> b1_drv_o == !$past(oe_b1_ni));
  assert_drv_b2_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> b2_drv_o == !$past(oe_b2_ni));
endmodule

bind bus_exchanger bus_exchanger_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_drv_o  (a_drv_o),
  .ld1_ni   (ld1_ni),
  .ld2_ni   (ld2_ni),
  .b1_i     (b1_i),
  .b2_i     (b2_i),
  .b1_o     (b1_o),
  .b2_o     (b2_o),
  .b1_drv_o (b1_drv_o),
  .b2_drv_o (b2_drv_o),
  .sel_i    (sel_i),
  .oe_a_ni  (oe_a_ni),
  .oe_b1_ni (oe_b1_ni),
  .oe_b2_ni (oe_b2_ni)
);

// File: tb/bus_exchanger_tb.sv
`timescale 1ns/1ps
module bus_exchanger_tb;
  localparam int W = 12;

  typedef struct packed {
    logic         ld1_n;
    logic         ld2_n;
    logic         sel;
    logic         oa_n;
    logic         o1_n;
    logic         o2_n;
    logic [W-1:0] a;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h123, 12'h0A1, 12'h0B1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h456, 12'h0A2, 12'h0B2},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h789, 12'h0A3, 12'h0B3},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'hABC, 12'h0A4, 12'h0B4},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'hDEF, 12'h0A5, 12'h0B5},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'hFFF, 12'h0A6, 12'h0B6},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 12'h0A7, 12'h0B7},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'h5A5, 12'h0A8, 12'h0B8},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h3C3, 12'h0A9, 12'h0B9},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h111, 12'h0AA, 12'h0BA}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic         ld1_ni = 1'b1, ld2_ni = 1'b1, sel_i = 1'b1;
  logic         oe_a_ni = 1'b1, oe_b1_ni = 1'b1, oe_b2_ni = 1'b1;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic         a_drv_o, b1_drv_o, b2_drv_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  logic [W-1:0] m_a, m_b1, m_b2;
  logic         m_sel, m_da, m_d1, m_d2;

  always #2.5 clk_i = ~clk_i;

  bus_exchanger #(.DATA_W(W)) u_dut (
    .clk_i, .rst_ni, .a_i, .a_o, .a_drv_o, .ld1_ni, .ld2_ni, .b1_i, .b2_i,
    .b1_o, .b2_o, .b1_drv_o, .b2_drv_o, .sel_i, .oe_a_ni, .oe_b1_ni, .oe_b2_ni
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a = '0; m_b1 = '0; m_b2 = '0; m_sel = 1'b1;
    m_da = 1'b0; m_d1 = 1'b0; m_d2 = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    ld1_ni = v.ld1_n; ld2_ni = v.ld2_n; sel_i = v.sel;
    oe_a_ni = v.oa_n; oe_b1_ni = v.o1_n; oe_b2_ni = v.o2_n;
    a_i = v.a; b1_i = v.b1; b2_i = v.b2;
  endtask

  // one clock: inputs already driven; update reference at the edge
  task automatic tick(input vec_t v);
    @(posedge clk_i);
    m_a = m_sel ? v.b1 : v.b2;
    m_sel = v.sel;
    if (!v.ld1_n) m_b1 = v.a;
    if (!v.ld2_n) m_b2 = v.a;
    m_da = ~v.oa_n; m_d1 = ~v.o1_n; m_d2 = ~v.o2_n;
    @(negedge clk_i);
  endtask

  task automatic step(input vec_t v);
    drive(v);
    tick(v);
  endtask

  function automatic vec_t mk(input logic l1, input logic l2, input logic s,
                              input logic [W-1:0] a, input logic [W-1:0] b1,
                              input logic [W-1:0] b2);
    vec_t v;
    v.ld1_n = l1; v.ld2_n = l2; v.sel = s;
    v.oa_n = 1'b1; v.o1_n = 1'b1; v.o2_n = 1'b1;
    v.a = a; v.b1 = b1; v.b2 = b2;
    return v;
  endfunction

  initial begin
    vec_t v;
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 lanes", {8'h0, b2_o, b1_o}, 32'h0);
    chk("R1 a_o", {20'h0, a_o}, 32'h0);
    chk("R1 drive flags", {29'h0, a_drv_o, b1_drv_o, b2_drv_o}, 32'h0);
    rst_ni = 1'b1;

    // table walk: R2 R3 R6 R9 R10
    for (int i = 0; i < 10; i++) begin
      step(VECS[i]);
      chk("R2 lane1", {20'h0, b1_o}, {20'h0, m_b1});
      chk("R3 lane2", {20'h0, b2_o}, {20'h0, m_b2});
      chk("R6 return", {20'h0, a_o}, {20'h0, m_a});
      chk("R9 R10 drive flags", {29'h0, a_drv_o, b1_drv_o, b2_drv_o},
          {29'h0, m_da, m_d1, m_d2});
    end

    // R5: packing two consecutive words
    step(mk(1'b0, 1'b1, 1'b1, 12'h123, 12'h0, 12'h0));
    step(mk(1'b1, 1'b0, 1'b1, 12'hABC, 12'h0, 12'h0));
    chk("R5 packed word", {8'h0, b2_o, b1_o}, 32'h00ABC123);
    step(mk(1'b1, 1'b1, 1'b1, 12'hFFF, 12'h0, 12'h0));
    chk("R2 R3 hold", {8'h0, b2_o, b1_o}, 32'h00ABC123);

    // R4: both enables low
    step(mk(1'b0, 1'b0, 1'b1, 12'h5A5, 12'h0, 12'h0));
    chk("R4 both lanes", {8'h0, b2_o, b1_o}, 32'h005A55A5);

    // R8: select latency (select register currently 1)
    step(mk(1'b1, 1'b1, 1'b0, 12'h0, 12'h111, 12'h222));
    chk("R8 old select used", {20'h0, a_o}, 32'h111);
    step(mk(1'b1, 1'b1, 1'b0, 12'h0, 12'h333, 12'h444));
    chk("R8 new select used", {20'h0, a_o}, 32'h444);

    // R7: mid-cycle input changes do not reach the outputs
    v = mk(1'b0, 1'b0, 1'b1, 12'hEEE, 12'h777, 12'h888);
    drive(v);
    #1;
    chk("R7 a_o before edge", {20'h0, a_o}, 32'h444);
    chk("R7 lanes before edge", {8'h0, b2_o, b1_o}, 32'h005A55A5);
    tick(v);
    chk("R7 a_o after edge", {20'h0, a_o}, 32'h888);

    // R9: enable latency
    v = mk(1'b1, 1'b1, 1'b1, 12'h0, 12'h0, 12'h0);
    v.oa_n = 1'b0;
    drive(v);
    #1;
    chk("R9 a_drv before edge", {31'h0, a_drv_o}, 32'h0);
    tick(v);
    chk("R9 a_drv after edge", {31'h0, a_drv_o}, 32'h1);
    chk("R10 other flags idle", {30'h0, b1_drv_o, b2_drv_o}, 32'h0);

    // R1: reset applied mid-run
    rst_ni = 1'b0;
    #1;
    model_reset();
    chk("R1 mid-run lanes", {8'h0, b2_o, b1_o}, 32'h0);
    chk("R1 mid-run flags", {29'h0, a_drv_o, b1_drv_o, b2_drv_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: select resets to lane 1
    step(mk(1'b1, 1'b1, 1'b0, 12'h0, 12'h9C9, 12'h6D6));
    chk("R1 select default lane1", {20'h0, a_o}, 32'h9C9);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule